// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block sits beside a memory shared by several bus masters and gives them a lock-free way to update shared data. A master first issues a load-exclusive, which leaves a reservation for that master on the accessed word. It later issues a store-exclusive to the same word. The monitor lets that store through only if no other write reached the word in between. If the reservation is gone, the store is dropped and a nonzero status goes back so that software can retry.

All masters share one request bus, which carries one request per cycle. The monitor never holds a request back and has no locking output, so ordinary reads and writes pass without any delay. Every request is answered in the following cycle with a status bit. In the same cycle the monitor gives a memory write strobe, which is set only for writes that may reach memory. Each master has one reservation register that holds a valid bit and a word address. Byte offset bits take no part in any address comparison.

Top module: `excl_monitor`

## Requirements
- R1: After reset no master holds a reservation: resp_valid and mem_we are 0, and a store-exclusive from any master fails.
- R2: A load-exclusive (req_write=0, req_excl=1) followed by a store-exclusive (req_write=1, req_excl=1) from the same master to the same word succeeds: resp_fail=0, mem_we=1, and mem_addr/mem_wdata carry that store's address and data.
- R3: A failing store-exclusive returns resp_fail=1 and leaves mem_we at 0.
- R4: An ordinary write (req_write=1, req_excl=0) from any master to a reserved word clears every reservation on that word, so a later store-exclusive to it fails.
- R5: Every ordinary write gives mem_we=1 with its address and data one cycle after the request. No request is ever stalled.
- R6: A store-exclusive clears the issuing master's reservation whether it succeeds or fails.
- R7: A successful store-exclusive clears the reservations of all other masters on the same word.
- R8: A new load-exclusive from a master replaces that master's earlier reservation.
- R9: A store-exclusive to a word other than the master's reserved word fails.
- R10: Addresses are compared on bits [ADDR_W-1:2] only, so the two low byte-offset bits are ignored.
- R11: resp_valid is 1 in exactly the cycle after each request (req_valid=1) and 0 otherwise.
- R12: Ordinary reads, and writes to other words, leave reservations unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | A request is present this cycle |
| req_id | input | ID_W | Issuing master number |
| req_addr | input | ADDR_W | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_excl | input | 1 | 1 = exclusive access |
| req_wdata | input | DATA_W | Write data |
| resp_valid | output | 1 | Response for the previous cycle's request |
| resp_fail | output | 1 | 1 = store-exclusive failed; 0 otherwise |
| mem_we | output | 1 | Write may be applied to memory |
| mem_addr | output | ADDR_W | Address of the last write request |
| mem_wdata | output | DATA_W | Data of the last write request |

## Verification
Reservation state can only be seen through the outcome of a store-exclusive. A reservation that is lost, stale or wrongly kept shows up as a wrong resp_fail and mem_we pair on the next store-exclusive from the affected master. That is the cycle after that store is issued, which may be many cycles after the fault itself. The random mix therefore uses only a handful of words, so that reservations are probed often. A shadow model in the bench predicts each status. A fault in the decision logic shows up one cycle after the offending request.

// File: rtl/excl_monitor_pkg.sv
package excl_monitor_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_LDX   = 2'd2,
    OP_STX   = 2'd3
  } excl_op_e;
endpackage

// File: rtl/excl_rst_sync.sv
module excl_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/excl_resv_slot.sv
module excl_resv_slot #(
  parameter int WORD_W = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic [WORD_W-1:0] set_word,
  output logic              valid_o,
  output logic [WORD_W-1:0] word_o
);
  logic              vld_q, vld_d;
  logic [WORD_W-1:0] word_q;

  always_comb begin
    vld_d = vld_q;
    if (set_en)      vld_d = 1'b1;
    else if (clr_en) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      word_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (set_en) word_q <= set_word;
    end
  end

  assign valid_o = vld_q;
  assign word_o  = word_q;

  // R2 R8
  resv_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> (valid_o && word_o == $past(set_word)));

  // R6
  resv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en) |=> !valid_o);
endmodule

// File: rtl/excl_decide.sv
module excl_decide
  import excl_monitor_pkg::*;
#(
  parameter int N_MASTERS = 4,
  parameter int ID_W      = 2,
  parameter int WORD_W    = 30
) (
  input  logic                             active,
  input  excl_op_e                         op,
  input  logic [ID_W-1:0]                  id,
  input  logic [WORD_W-1:0]                word,
  input  logic [N_MASTERS-1:0]             slot_vld,
  input  logic [N_MASTERS-1:0][WORD_W-1:0] slot_word,
  output logic [N_MASTERS-1:0]             set_vec,
  output logic [N_MASTERS-1:0]             clr_vec,
  output logic                             pass,
  output logic                             fail
);
  logic [N_MASTERS-1:0] match;
  logic [N_MASTERS-1:0] own;

  for (genvar i = 0; i < N_MASTERS; i++) begin : g_cmp
    assign match[i] = slot_vld[i] && (slot_word[i] == word);
    assign own[i]   = (id == ID_W'(i));
  end

  logic own_hit;
  assign own_hit = |(match & own);

  always_comb begin
    set_vec = '0;
    clr_vec = '0;
    pass    = 1'b0;
    fail    = 1'b0;
    if (active) begin
      unique case (op)
        OP_LDX:   set_vec = own;
        OP_WRITE: begin
          clr_vec = match;
          pass    = 1'b1;
        end
        OP_STX: begin
          if (own_hit) begin
            clr_vec = match | own;
            pass    = 1'b1;
          end else begin
            clr_vec = own;
            fail    = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import excl_monitor_pkg::*;
#(
  parameter int N_MASTERS = 4,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  localparam int ID_W     = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1,
  localparam int WORD_W   = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ID_W-1:0]   req_id,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_excl,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              resp_valid,
  output logic              resp_fail,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  logic rst_n_s;

  excl_rst_sync u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .rst_n_o(rst_n_s)
  );

  excl_op_e op;
  always_comb begin
    if (req_excl) op = req_write ? OP_STX : OP_LDX;
    else          op = req_write ? OP_WRITE : OP_READ;
  end

  logic [WORD_W-1:0]                word;
  logic [N_MASTERS-1:0]             slot_vld;
  logic [N_MASTERS-1:0][WORD_W-1:0] slot_word;
  logic [N_MASTERS-1:0]             set_vec, clr_vec;
  logic                             pass, fail;

  assign word = req_addr[ADDR_W-1:2];

  excl_decide #(
    .N_MASTERS(N_MASTERS),
    .ID_W     (ID_W),
    .WORD_W   (WORD_W)
  ) u_decide (
    .active   (req_valid),
    .op       (op),
    .id       (req_id),
    .word     (word),
    .slot_vld (slot_vld),
    .slot_word(slot_word),
    .set_vec  (set_vec),
    .clr_vec  (clr_vec),
    .pass     (pass),
    .fail     (fail)
  );

  for (genvar i = 0; i < N_MASTERS; i++) begin : g_slot
    excl_resv_slot #(.WORD_W(WORD_W)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n_s),
      .set_en  (set_vec[i]),
      .clr_en  (clr_vec[i]),
      .set_word(word),
      .valid_o (slot_vld[i]),
      .word_o  (slot_word[i])
    );
  end

  logic              rv_q, rv_d, rf_q, rf_d, we_q, we_d, cap_en;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  always_comb begin
    rv_d   = req_valid;
    rf_d   = req_valid && fail;
    we_d   = req_valid && pass;
    cap_en = req_valid && req_write;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rv_q   <= 1'b0;
      rf_q   <= 1'b0;
      we_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      rv_q <= rv_d;
      rf_q <= rf_d;
      we_q <= we_d;
      if (cap_en) begin
        addr_q <= req_addr;
        data_q <= req_wdata;
      end
    end
  end

  assign resp_valid = rv_q;
  assign resp_fail  = rf_q;
  assign mem_we     = we_q;
  assign mem_addr   = addr_q;
  assign mem_wdata  = data_q;

  // R11
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    req_valid |=> resp_valid);

  // R11
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !req_valid |=> !resp_valid);

  // R3
  fail_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    resp_fail |-> (resp_valid && !mem_we));

  // R5
  plain_write_passes_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (req_valid && req_write && !req_excl) |=> (mem_we && !resp_fail));
endmodule

// File: tb/excl_monitor_bench.sv
`timescale 1ns/1ps
module excl_monitor_bench;
  localparam int N  = 4;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int IW = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  logic          req_valid, req_write, req_excl;
  logic [IW-1:0] req_id;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          resp_valid, resp_fail, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;

  excl_monitor #(.N_MASTERS(N), .ADDR_W(AW), .DATA_W(DW)) u_excl_monitor (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
    .req_addr(req_addr), .req_write(req_write), .req_excl(req_excl),
    .req_wdata(req_wdata), .resp_valid(resp_valid), .resp_fail(resp_fail),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  bit            mv[N];
  logic [AW-3:0] ma[N];

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit model_step(int id, logic [AW-1:0] a, bit w, bit x, output bit fl);
    logic [AW-3:0] wd = a[AW-1:2];
    bit ok;
    fl = 0;
    if (!w && x) begin
      mv[id] = 1; ma[id] = wd;
      return 0;
    end
    if (w && !x) begin
      for (int i = 0; i < N; i++) if (mv[i] && ma[i] == wd) mv[i] = 0;
      return 1;
    end
    if (w && x) begin
      ok = mv[id] && ma[id] == wd;
      mv[id] = 0;
      if (ok) for (int i = 0; i < N; i++) if (mv[i] && ma[i] == wd) mv[i] = 0;
      fl = !ok;
      return ok;
    end
    return 0;
  endfunction

  task automatic issue(int id, logic [AW-1:0] a, bit w, bit x, logic [DW-1:0] d, string tag);
    bit we, fl;
    we = model_step(id, a, w, x, fl);
    req_valid = 1; req_id = IW'(id); req_addr = a;
    req_write = w; req_excl = x; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk("R11", "resp_valid", 64'(resp_valid), 64'd1);
    chk(tag, "resp_fail", 64'(resp_fail), 64'(fl));
    chk(fl ? "R3" : tag, "mem_we", 64'(mem_we), 64'(we));
    if (we) begin
      chk(w && !x ? "R5" : tag, "mem_addr", 64'(mem_addr), 64'(a));
      chk(w && !x ? "R5" : tag, "mem_wdata", 64'(mem_wdata), 64'(d));
    end
  endtask

  task automatic idle_check();
    @(posedge clk);
    @(negedge clk);
    chk("R11", "idle resp_valid", 64'(resp_valid), 64'd0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < N; i++) begin mv[i] = 0; ma[i] = '0; end
    rst_n = 0; req_valid = 0; req_id = '0; req_addr = '0;
    req_write = 0; req_excl = 0; req_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1", "reset resp_valid", 64'(resp_valid), 64'd0);
    chk("R1", "reset mem_we", 64'(mem_we), 64'd0);
    for (int i = 0; i < N; i++) issue(i, 32'h100, 1, 1, 32'hA0 + i, "R1");

    // R2 basic pair, then R6 second store fails
    issue(1, 32'h200, 0, 1, 0, "R2");
    issue(1, 32'h200, 1, 1, 32'hCAFE, "R2");
    issue(1, 32'h200, 1, 1, 32'hBEEF, "R6");
    // R6 a failing store also clears
    issue(0, 32'h220, 0, 1, 0, "R6");
    issue(0, 32'h224, 1, 1, 32'h1, "R9");
    issue(0, 32'h220, 1, 1, 32'h2, "R6");

    // R4 other master writes reserved word
    issue(2, 32'h300, 0, 1, 0, "R4");
    issue(0, 32'h302, 1, 0, 32'h55, "R5");
    issue(2, 32'h300, 1, 1, 32'h66, "R4");

    // R12 unrelated write and read leave reservation
    issue(3, 32'h400, 0, 1, 0, "R12");
    issue(0, 32'h404, 1, 0, 32'h77, "R5");
    issue(1, 32'h400, 0, 0, 0, "R12");
    idle_check();
    issue(3, 32'h400, 1, 1, 32'h88, "R12");

    // R7 winner clears other masters on the same word
    issue(0, 32'h500, 0, 1, 0, "R7");
    issue(1, 32'h500, 0, 1, 0, "R7");
    issue(0, 32'h500, 1, 1, 32'h99, "R7");
    issue(1, 32'h500, 1, 1, 32'h9A, "R7");

    // R8 replacement
    issue(2, 32'h600, 0, 1, 0, "R8");
    issue(2, 32'h700, 0, 1, 0, "R8");
    issue(2, 32'h700, 1, 1, 32'h11, "R8");
    issue(2, 32'h600, 0, 1, 0, "R8");
    issue(2, 32'h700, 0, 1, 0, "R8");
    issue(2, 32'h600, 1, 1, 32'h12, "R8");

    // R9 different word
    issue(3, 32'h800, 0, 1, 0, "R9");
    issue(3, 32'h804, 1, 1, 32'h13, "R9");

    // R10 byte offsets ignored
    issue(0, 32'h901, 0, 1, 0, "R10");
    issue(0, 32'h902, 1, 1, 32'h14, "R10");

    // random mix on a small word pool
    for (int n = 0; n < 3000; n++) begin
      int id = int'($urandom_range(N - 1));
      logic [AW-1:0] a = 32'hA00 + 32'($urandom_range(3) * 4) + 32'($urandom_range(3));
      int k = int'($urandom_range(9));
      bit w = (k >= 4);
      bit x = (k < 2) || (k >= 6);
      if ($urandom_range(7) == 0) idle_check();
      issue(id, a, w, x, $urandom, "R2");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule